// File: doc/BRIEF.md
# Error Record Queue with Overflow Marker

This block holds error and event records in arrival order until a controller reads them. Each record pairs a signed numeric error code with a small message index. The index stands in for the descriptive text, which is kept elsewhere. Producers push one record per cycle. The controller sees the oldest record on the read outputs at all times and consumes it with a pop. When nothing is stored, the read outputs show a "no error" record: code 0 and the no-error index.

Records are never lost silently. If a producer pushes while all slots are occupied and nothing is popped in the same cycle, the newest stored record is overwritten with the overflow code -350 and the overflow index. The controller can then tell that entries went missing. Only one such marker is kept, so later pushes into a full queue whose newest slot already holds the marker are discarded. A clear input empties the queue in one cycle. A not-empty flag feeds status summary logic.

Top module: `err_queue`

## Requirements
- R1: After synchronous active-low reset the queue is empty: `not_empty` is 0, `rd_code` is 0 and `rd_idx` is the no-error index (default 0).
- R2: Records are returned in the order they were pushed. `rd_code`/`rd_idx` show the oldest stored record, and a pop removes it at the next clock edge.
- R3: A pop on an empty queue changes nothing. The outputs stay at code 0 with the no-error index, and a record pushed afterwards is read back correctly.
- R4: `not_empty` is 1 exactly when at least one record is stored.
- R5: A push into a full queue (DEPTH records, default 8) with no pop in the same cycle replaces the newest stored record with code -350 (0xFEA2) and the overflow index (default 0xFF). The older records are unchanged.
- R6: While the newest slot of a full queue holds the overflow marker, further pushes are discarded. After the queue is drained it is empty again, with exactly one marker having been read.
- R7: A push and a pop in the same cycle on a full queue act as pop-then-push. The oldest record leaves, the new record is stored as the newest, and no overflow marker is written.
- R8: Clear empties the queue in one cycle and takes priority over a push or pop in the same cycle.
- R9: Stored records keep their values for any number of idle cycles until they are popped.
- R10: A push and a pop in the same cycle on an empty queue store the pushed record. The pop has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Empty the queue at the next edge |
| push | input | 1 | Store the record on `push_code`/`push_idx` |
| push_code | input | CODE_W (16) | Signed error code to store |
| push_idx | input | IDX_W (8) | Message index to store |
| pop | input | 1 | Remove the oldest record |
| rd_code | output | CODE_W (16) | Code of the oldest record, 0 when empty |
| rd_idx | output | IDX_W (8) | Index of the oldest record, no-error index when empty |
| not_empty | output | 1 | At least one record is stored |

## Verification
The bench drives overflow in two ways.
- It pushes one record into a full queue. A design that dropped the record, or wrote the marker into the wrong slot, would show the final pushed code instead of -350, or would lose an older entry.
- It pushes several more records after the marker is in place. A design that kept writing markers would read back a second marker or leave the queue non-empty after draining.

Other corner cases:
- Push and pop together on a full queue must not produce a marker. A design that tested fullness before the pop would show -350.
- Pops on an empty queue must not move the pointers. Underflowed pointers would return a stale or garbage record after the next push.
- Clear together with a push checks that clear has priority.
- Repeated fill and drain runs carry the pointers across the wrap point.

// File: rtl/err_q_pkg.sv
// Package: shared constants and the write-source encoding for the error queue.
// Assumes: codes are two's complement; the overflow code fits in the code width.
package err_q_pkg;

    // Code stored when a push finds the queue full.
    localparam int OVF_CODE = -350;
    // Code presented when the queue holds nothing.
    localparam int NOERR_CODE = 0;

    // What, if anything, is written into the record store this cycle.
    typedef enum logic [1:0] {
        WS_NONE = 2'd0,
        WS_DATA = 2'd1,
        WS_MARK = 2'd2
    } wsrc_e;

endpackage

// File: rtl/err_q_store.sv
// Module: record storage for the error queue.
// One write port and one combinational read port, one register per slot.
// Assumes: the controller never writes and reads a slot it considers
// invalid; slot contents are not reset (validity is tracked elsewhere).
module err_q_store #(
    parameter int DEPTH = 8,
    parameter int REC_W = 24,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [REC_W-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [REC_W-1:0] rdata
);

    logic [REC_W-1:0] slot_q [DEPTH];

    // One register per slot, loaded when the write address selects it.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(s))) begin
                slot_q[s] <= wdata;
            end
        end
    end

    // Combinational read of the slot at the read pointer.
    always_comb begin
        rdata = slot_q[raddr];
    end

endmodule

// File: rtl/err_q_ctrl.sv
// Module: pointer, occupancy and overflow control for the error queue.
// It decides each cycle whether a record is popped, stored, replaced by
// the overflow marker, or discarded. A pop on an empty queue is ignored.
// Push with pop on a full queue is pop-then-push. Clear has top priority.
// Assumes: DEPTH >= 2.
module err_q_ctrl #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 push,
    input  logic                 pop,
    output logic                 empty,
    output err_q_pkg::wsrc_e     wsrc,
    output logic [AW-1:0]        waddr,
    output logic [AW-1:0]        raddr
);
    import err_q_pkg::*;

    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_SLOT = AW'(DEPTH - 1);

    logic [AW-1:0] wr_ptr_q, rd_ptr_q, newest;
    logic [CW-1:0] count_q;
    logic          mark_q;
    logic          full, do_pop, do_push, do_mark;

    // Wrap-aware step of a slot pointer.
    function automatic logic [AW-1:0] step_up(input logic [AW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + AW'(1);
    endfunction

    // Occupancy flags and the slot holding the newest record.
    always_comb begin
        empty  = (count_q == '0);
        full   = (count_q == FULL_CNT);
        newest = (wr_ptr_q == '0) ? LAST_SLOT : wr_ptr_q - AW'(1);
    end

    // Per-cycle decision: pop, store, write the marker, or discard.
    always_comb begin
        do_pop  = !clr && pop && !empty;
        do_push = !clr && push && (!full || do_pop);
        do_mark = !clr && push && full && !do_pop && !mark_q;
        if (do_push) begin
            wsrc  = WS_DATA;
            waddr = wr_ptr_q;
        end else if (do_mark) begin
            wsrc  = WS_MARK;
            waddr = newest;
        end else begin
            wsrc  = WS_NONE;
            waddr = wr_ptr_q;
        end
        raddr = rd_ptr_q;
    end

    // Pointer, count and marker-present state update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            mark_q   <= 1'b0;
        end else begin
            if (do_push) wr_ptr_q <= step_up(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= step_up(rd_ptr_q);
            case ({do_push, do_pop})
                2'b10:   count_q <= count_q + CW'(1);
                2'b01:   count_q <= count_q - CW'(1);
                default: count_q <= count_q;
            endcase
            if (do_push)      mark_q <= 1'b0;
            else if (do_mark) mark_q <= 1'b1;
        end
    end

    // R4
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_CNT);

    // R3
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !clr) |=> (count_q == '0));

    // R5
    overflow_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (count_q == FULL_CNT && mark_q));

    // R7
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop && !clr) |=> (count_q == FULL_CNT && !mark_q));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count_q == '0));

endmodule

// File: rtl/err_queue.sv
// Module: error record queue (top).
// Stores {code, index} records first-in first-out. The oldest record is
// shown on the read outputs, or the no-error record when empty. A push
// into a full queue replaces the newest record with the overflow marker.
// Assumes: DEPTH >= 2; the overflow code fits in CODE_W bits.
module err_queue #(
    parameter int DEPTH = 8,
    parameter int CODE_W = 16,
    parameter int IDX_W = 8,
    parameter logic [IDX_W-1:0] NOERR_IDX = '0,
    parameter logic [IDX_W-1:0] OVF_IDX = '1,
    localparam int REC_W = CODE_W + IDX_W,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [CODE_W-1:0] push_code,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    output logic [CODE_W-1:0] rd_code,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              not_empty
);
    import err_q_pkg::*;

    localparam logic [CODE_W-1:0] OVF_VAL   = CODE_W'(OVF_CODE);
    localparam logic [CODE_W-1:0] NOERR_VAL = CODE_W'(NOERR_CODE);

    wsrc_e            wsrc;
    logic             empty, we;
    logic [AW-1:0]    waddr, raddr;
    logic [REC_W-1:0] wdata, rdata;

    err_q_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .push  (push),
        .pop   (pop),
        .empty (empty),
        .wsrc  (wsrc),
        .waddr (waddr),
        .raddr (raddr)
    );

    // Pick the record to write: the pushed one or the overflow marker.
    always_comb begin
        we    = (wsrc != WS_NONE);
        wdata = (wsrc == WS_MARK) ? {OVF_VAL, OVF_IDX} : {push_code, push_idx};
    end

    err_q_store #(.DEPTH(DEPTH), .REC_W(REC_W)) u_store (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    // Present the oldest record, or the no-error record when empty.
    always_comb begin
        not_empty = !empty;
        if (empty) begin
            rd_code = NOERR_VAL;
            rd_idx  = NOERR_IDX;
        end else begin
            {rd_code, rd_idx} = rdata;
        end
    end

    // R2
    push_vis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !clr) |=> not_empty);

endmodule

// File: tb/err_queue_test.sv
// Bench: directed scenarios for err_queue, one task per scenario.
// Inputs change on the falling edge; outputs are sampled on the falling edge
// after the rising edge that acted on them.
module err_queue_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0, push = 1'b0, pop = 1'b0;
    logic [15:0] push_code = '0;
    logic [7:0]  push_idx = '0;
    logic [15:0] rd_code;
    logic [7:0]  rd_idx;
    logic        not_empty;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    localparam logic [15:0] OVF = 16'hFEA2;  // -350
    localparam logic [7:0]  OVF_I = 8'hFF;

    always #10 clk = ~clk;  // 50 MHz

    err_queue uut (
        .clk(clk), .rst_n(rst_n), .clr(clr), .push(push),
        .push_code(push_code), .push_idx(push_idx), .pop(pop),
        .rd_code(rd_code), .rd_idx(rd_idx), .not_empty(not_empty)
    );

    task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, then inputs return to idle.
    task automatic drive(input logic p, input logic [15:0] c, input logic [7:0] i,
                         input logic pp, input logic cl);
        push = p; push_code = c; push_idx = i; pop = pp; clr = cl;
        @(negedge clk);
        push = 1'b0; pop = 1'b0; clr = 1'b0;
    endtask

    task automatic expect_pop(input string tag, input logic [15:0] c, input logic [7:0] i);
        check(tag, {rd_code, rd_idx}, {c, i});
        drive(1'b0, '0, '0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        check("R1 not_empty", {23'd0, not_empty}, 24'd0);
        check("R1 record", {rd_code, rd_idx}, 24'd0);
    endtask

    task automatic t_order();
        drive(1, 16'hFFFB, 8'd3, 0, 0);
        drive(1, 16'd100, 8'd7, 0, 0);
        drive(1, 16'h8000, 8'd1, 0, 0);
        check("R4 not_empty set", {23'd0, not_empty}, 24'd1);
        expect_pop("R2 first", 16'hFFFB, 8'd3);
        expect_pop("R2 second", 16'd100, 8'd7);
        expect_pop("R2 third", 16'h8000, 8'd1);
        check("R4 not_empty clear", {23'd0, not_empty}, 24'd0);
    endtask

    task automatic t_empty_pop();
        for (int k = 0; k < 3; k++) drive(0, '0, '0, 1, 0);
        check("R3 empty record", {rd_code, rd_idx}, 24'd0);
        check("R3 still empty", {23'd0, not_empty}, 24'd0);
        drive(1, 16'd42, 8'd9, 0, 0);
        expect_pop("R3 after underflow attempt", 16'd42, 8'd9);
        check("R3 empty again", {23'd0, not_empty}, 24'd0);
    endtask

    task automatic t_pushpop_empty();
        drive(1, 16'd77, 8'd4, 1, 0);
        check("R10 stored", {23'd0, not_empty}, 24'd1);
        expect_pop("R10 record", 16'd77, 8'd4);
    endtask

    task automatic t_overflow();
        for (int k = 0; k < 8; k++) drive(1, 16'(10 + k), 8'(k), 0, 0);
        drive(1, 16'd500, 8'd50, 0, 0);
        for (int k = 0; k < 3; k++) drive(1, 16'(600 + k), 8'd60, 0, 0);
        for (int k = 0; k < 7; k++) expect_pop("R5 older kept", 16'(10 + k), 8'(k));
        expect_pop("R5 marker", OVF, OVF_I);
        check("R6 single marker", {23'd0, not_empty}, 24'd0);
        check("R6 empty record", {rd_code, rd_idx}, 24'd0);
    endtask

    task automatic t_full_swap();
        for (int k = 0; k < 8; k++) drive(1, 16'(20 + k), 8'(k + 1), 0, 0);
        check("R7 head before swap", {rd_code, rd_idx}, {16'd20, 8'd1});
        drive(1, 16'd99, 8'd33, 1, 0);
        for (int k = 1; k < 8; k++) expect_pop("R7 remaining", 16'(20 + k), 8'(k + 1));
        expect_pop("R7 new record, no marker", 16'd99, 8'd33);
        check("R7 drained", {23'd0, not_empty}, 24'd0);
    endtask

    task automatic t_clear();
        drive(1, 16'd1, 8'd1, 0, 0);
        drive(1, 16'd2, 8'd2, 0, 0);
        drive(1, 16'd3, 8'd3, 0, 1);
        check("R8 empty after clear", {23'd0, not_empty}, 24'd0);
        check("R8 record after clear", {rd_code, rd_idx}, 24'd0);
        drive(1, 16'd5, 8'd5, 0, 0);
        expect_pop("R8 fresh after clear", 16'd5, 8'd5);
    endtask

    task automatic t_persist();
        drive(1, 16'hFF00, 8'd11, 0, 0);
        drive(1, 16'd1234, 8'd12, 0, 0);
        repeat (50) @(negedge clk);
        expect_pop("R9 first kept", 16'hFF00, 8'd11);
        expect_pop("R9 second kept", 16'd1234, 8'd12);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_empty_pop();
        t_pushpop_empty();
        t_overflow();
        t_full_swap();
        t_clear();
        t_persist();
        t_overflow();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule